// File: doc/BRIEF.md
# Set/Clear Mask GPIO Port

This block is a 32-pin general-purpose I/O port on a simple one-cycle register bus. Software never writes the output latch directly. It writes a bit mask to a set register or to a clear register, and only the pins whose mask bit is 1 change. Either of those writes also moves the selected pins from tristate into driven mode. A separate mask write returns pins to tristate. No direction register exists: driving a pin is always a side effect of giving it a value.

Several offsets mean one thing on a read and another on a write. The mode offset reads back the drive state of every pin and, on a write, releases the selected pins. The set offset reads back the latch. The pin offset reads the synchronized level of every pin and, on a write, loads a mask that chooses which pins report their level. Pin inputs pass through a synchronizer chain before they reach the readback. The block drives per-pin output-enable and output-value signals toward the pads.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, every pin is tristated (pin_oe all 0), the output latch (pin_out) is all 0, the input-enable mask is all 1, and rd_valid is 0.
- R2: A read at offset 0x100 returns the mode word, where bit i is 1 when pin i is driven. A write at 0x100 tristates every pin whose written bit is 1.
- R3: A write at offset 0x108 sets the latch bit of every pin whose written bit is 1, and it also drives those pins.
- R4: A write at offset 0x10C clears the latch bit of every pin whose written bit is 1, and it also drives those pins.
- R5: For writes at 0x100, 0x108 and 0x10C, pins whose written bit is 0 keep both their mode and their latch value.
- R6: A read at offset 0x108 returns the output latch. pin_out always equals the latch, and pin_oe always equals the mode word.
- R7: A read at offset 0x110 returns, for each pin, its input level ANDed with its input-enable bit. The level passes through SYNC_STAGES flops, so with the default of 2, a read captured at the third rising edge after a pin change is the first read to show the new level.
- R8: A write at offset 0x110 loads the whole input-enable mask from the written word. It does not change mode or latch.
- R9: A read at any other offset, including the write-only offset 0x10C, returns 0. A write at an unmapped offset changes neither mode, latch nor input-enable mask.
- R10: rd_data and rd_valid are registered. rd_valid is 1 exactly in the cycle after a cycle with bus_rd high, and rd_data then holds the word selected by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW (12) | Byte offset of the access |
| bus_wdata | input | DW (32) | Write data / bit mask |
| rd_data | output | DW (32) | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |
| pin_in | input | NPINS (32) | Raw pin levels from the pads |
| pin_oe | output | NPINS (32) | Per-pin drive enable (1 = driven) |
| pin_out | output | NPINS (32) | Per-pin output value |

## Verification
The bench uses the default parameters: 32 pins on a 32-bit data path with a two-flop synchronizer. Every set, clear, tristate and enable mask therefore covers all bits, including bit 31, and no bits are left zero-padded. With the default depth of two, the exact cycle in which a pin change first appears can be checked with three back-to-back reads. Random masks over the four mapped offsets and over unmapped offsets reach the cases where set and clear writes overlap and where pins already driven are written again.

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int NPINS       = 32,
  parameter int DW          = 32,
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] MODE_OFS = 12'h100,
  parameter logic [AW-1:0] OSET_OFS = 12'h108,
  parameter logic [AW-1:0] OCLR_OFS = 12'h10C,
  parameter logic [AW-1:0] PIN_OFS  = 12'h110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out
);

  logic [NPINS-1:0] mode_q, latch_q, ien_q;
  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [DW-1:0]    rd_word;

  wire [NPINS-1:0] wmask  = bus_wdata[NPINS-1:0];
  wire             wr_mode = bus_wr && (bus_addr == MODE_OFS);
  wire             wr_set  = bus_wr && (bus_addr == OSET_OFS);
  wire             wr_clr  = bus_wr && (bus_addr == OCLR_OFS);
  wire             wr_pin  = bus_wr && (bus_addr == PIN_OFS);
  wire [NPINS-1:0] pin_lvl = sync_q[SYNC_STAGES-1] & ien_q;

  assign pin_oe  = mode_q;
  assign pin_out = latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      latch_q <= '0;
      ien_q   <= '1;
    end else begin
      if (wr_mode)              mode_q <= mode_q & ~wmask;
      else if (wr_set || wr_clr) mode_q <= mode_q | wmask;
      if (wr_set)      latch_q <= latch_q | wmask;
      else if (wr_clr) latch_q <= latch_q & ~wmask;
      if (wr_pin) ien_q <= wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      MODE_OFS: rd_word[NPINS-1:0] = mode_q;
      OSET_OFS: rd_word[NPINS-1:0] = latch_q;
      PIN_OFS:  rd_word[NPINS-1:0] = pin_lvl;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_word;
    end
  end

endmodule

module gpio_setclr_port_chk #(
  parameter int NPINS = 32,
  parameter int DW    = 32,
  parameter int AW    = 12,
  parameter logic [AW-1:0] MODE_OFS = 12'h100,
  parameter logic [AW-1:0] OSET_OFS = 12'h108,
  parameter logic [AW-1:0] OCLR_OFS = 12'h10C,
  parameter logic [AW-1:0] PIN_OFS  = 12'h110
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    rd_data,
  input logic             rd_valid,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_out
);

  wire [NPINS-1:0] m = bus_wdata[NPINS-1:0];
  wire mapped_rd = (bus_addr == MODE_OFS) || (bus_addr == OSET_OFS) || (bus_addr == PIN_OFS);
  wire drive_wr  = bus_wr && ((bus_addr == MODE_OFS) || (bus_addr == OSET_OFS) || (bus_addr == OCLR_OFS));

  AST_TRISTATE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == MODE_OFS |=> (pin_oe & $past(m)) == '0); // R2
  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OSET_OFS |=> ((pin_out & $past(m)) == $past(m)) && ((pin_oe & $past(m)) == $past(m))); // R3
  AST_CLR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OCLR_OFS |=> ((pin_out & $past(m)) == '0) && ((pin_oe & $past(m)) == $past(m))); // R4
  AST_UNSELECTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    drive_wr |=> (((pin_oe ^ $past(pin_oe)) | (pin_out ^ $past(pin_out))) & ~$past(m)) == '0); // R5
  AST_IEN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == PIN_OFS |=> $stable(pin_oe) && $stable(pin_out)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !mapped_rd |=> rd_data == '0); // R9
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_wr |=> $stable(pin_oe) && $stable(pin_out)); // R9
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid); // R10

endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(
  .NPINS(NPINS), .DW(DW), .AW(AW),
  .MODE_OFS(MODE_OFS), .OSET_OFS(OSET_OFS), .OCLR_OFS(OCLR_OFS), .PIN_OFS(PIN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
  .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/gpio_setclr_port_tb.sv
`timescale 1ns/1ps
module gpio_setclr_port_tb;
  localparam logic [11:0] A_MODE = 12'h100, A_SET = 12'h108, A_CLR = 12'h10C, A_PIN = 12'h110;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rd_data, pin_in = '0, pin_oe, pin_out;
  logic rd_valid;
  int total = 0, bad = 0;
  logic [31:0] e_mode = '0, e_lat = '0, e_ien = '1;
  logic [31:0] got;
  logic gotv;
  int seed_sink;

  always #2.5 clk = ~clk;

  gpio_setclr_port u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      A_MODE: return e_mode;
      A_SET:  return e_lat;
      A_PIN:  return pin_in & e_ien;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      A_MODE: e_mode = e_mode & ~d;
      A_SET:  begin e_mode = e_mode | d; e_lat = e_lat | d; end
      A_CLR:  begin e_mode = e_mode | d; e_lat = e_lat & ~d; end
      A_PIN:  e_ien = d;
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    got = rd_data; gotv = rd_valid;
  endtask

  task automatic chk_ports(input string tag);
    chk({tag, " pin_oe R6"}, pin_oe, e_mode);
    chk({tag, " pin_out R6"}, pin_out, e_lat);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid idle", {31'b0, rd_valid}, 32'h0);
    rd(A_MODE); chk("R1 mode read", got, 32'h0);
    chk("R10 valid", {31'b0, gotv}, 32'h1);
    @(negedge clk);
    chk("R10 valid drops", {31'b0, rd_valid}, 32'h0);

    // R3 set drives, R5 others untouched
    wr(A_SET, 32'h8000_0001); chk_ports("R3 set");
    rd(A_SET); chk("R6 latch read", got, 32'h8000_0001);
    rd(A_MODE); chk("R2 mode read", got, 32'h8000_0001);
    // R4 clear on undriven pin drives it low
    wr(A_CLR, 32'h0000_0100); chk_ports("R4 clr");
    chk("R4 oe bit8", pin_oe, 32'h8000_0101);
    wr(A_CLR, 32'h8000_0000); chk("R4 latch", pin_out, 32'h0000_0001);
    chk("R5 keep", pin_oe, 32'h8000_0101);
    // R2 tristate
    wr(A_MODE, 32'h8000_0001); chk("R2 tristate", pin_oe, 32'h0000_0100);
    chk("R2 latch kept", pin_out, 32'h0000_0001);
    // R9 unmapped
    wr(12'h004, 32'hFFFF_FFFF); chk_ports("R9 unmapped wr");
    rd(A_CLR); chk("R9 clr read zero", got, 32'h0);
    rd(12'h104); chk("R9 unmapped read", got, 32'h0);
    // R8 input-enable load does not touch drive
    wr(A_PIN, 32'h0000_FFFF); chk_ports("R8 ien");

    // R7 synchronizer latency: reads captured at edges 1,2,3 after a change
    pin_in = 32'hA5A5_A5A5;
    wr(A_PIN, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    pin_in = 32'h5A5A_5A5A;
    rd(A_PIN); chk("R7 edge1 old", got, 32'hA5A5_A5A5);
    rd(A_PIN); chk("R7 edge2 old", got, 32'hA5A5_A5A5);
    rd(A_PIN); chk("R7 edge3 new", got, 32'h5A5A_5A5A);
    wr(A_PIN, 32'h0F0F_0000);
    rd(A_PIN); chk("R8 masked level", got, 32'h0A0A_0000);

    for (int it = 0; it < 400; it++) begin
      logic [11:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 5);
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = d & $urandom;
      case (sel)
        0: a = A_MODE;
        1, 4: a = A_SET;
        2, 5: a = A_CLR;
        3: a = A_PIN;
        default: a = A_MODE;
      endcase
      if ($urandom_range(0, 7) == 0) begin
        a = 12'($urandom_range(0, 4095));
        if (a == A_MODE || a == A_SET || a == A_CLR || a == A_PIN) a = 12'h040;
      end
      wr(a, d);
      chk_ports("R5 random");
      if ($urandom_range(0, 3) == 0) begin
        pin_in = $urandom;
        repeat (3) @(negedge clk);
      end
      begin
        logic [11:0] ra;
        ra = (it % 5 == 4) ? 12'h0FC : ((it % 3 == 0) ? A_MODE : ((it % 3 == 1) ? A_SET : A_PIN));
        rd(ra);
        chk("R7 R9 random read", got, exp_read(ra));
        chk("R10 random valid", {31'b0, gotv}, 32'h1);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule